// File: doc/BRIEF.md
# Concealed Execution Interrupt Controller

This block tracks whether the processor is running trusted code in concealed mode and guards the general register contents when an interrupt arrives during that mode. Separate enter and exit commands switch concealed mode on and off. An interrupt taken while concealed code runs seals the register image. The image is enciphered as one chained chunk under the on-chip root key and written back over the registers. A keyed digest of the resulting ciphertext and the resume address are kept on chip. Only then is control handed to the operating-system handler, which can save and restore the registers without ever seeing plaintext.

When the handler returns, the block recomputes the digest over the register image it is given and compares the return address with the stored one. If both match, it deciphers the registers and resumes concealed execution. If either differs, it raises a security exception, clears the registers and drops back to normal mode. The cipher and digest are simple stand-ins, and the register file is a flat 16 x 32-bit vector.

The controller state machine has five states. NORMAL reports 00. RUN reports 10. SEAL reports 10. PARK reports 11. OPEN reports 11.

Its transitions are:
- NORMAL to RUN on enter.
- RUN to NORMAL on exit.
- RUN to SEAL on an interrupt.
- SEAL to PARK when the engine finishes.
- PARK to OPEN on return.
- OPEN to RUN on a good check.
- OPEN to NORMAL on a bad check.

Top module: `cem_irq_ctrl`

## Requirements
- R1: After reset, `in_cem` and `suspended` are 0, and `regs_we`, `handoff`, `resumed`, `sec_exc` and `fault` are all 0.
- R2: The state is reported as {`in_cem`,`suspended`}: 00 is normal, 10 is concealed-running, 11 is concealed-suspended. `enter_cmd` in normal moves to 10. `exit_cmd` in running moves to 00. `enter_cmd` or `exit_cmd` while suspended has no effect.
- R3: `irq_req` in the normal state has no effect: no event strobe fires and the state stays 00.
- R4: `irq_req` in the running state is accepted at a rising edge E. On the 17th rising edge after E, `regs_we` and `handoff` pulse high for one cycle, `regs_out` carries the sealed image, and the state reads 11 from that edge on.
- R5: Word i (bits 32i+31:32i) of the sealed image is c_i = p_i XOR k_i XOR c_(i-1), with c_(-1) = 0. Here k_i = root_key[32(i mod 4)+31 : 32(i mod 4)] XOR (i * 0x9E3779B9 mod 2^32), and p_i is word i of `regs_in` at edge E.
- R6: The resume address is `next_pc` sampled at edge E. The digest is keyed by `root_key` and covers every ciphertext word in order.
- R7: `ret_req` while suspended is accepted at edge E. The return succeeds when `ret_pc` equals the stored address and the digest of `regs_in` equals the stored digest. On the 17th edge after E, `resumed` and `regs_we` then pulse once, `regs_out` holds the deciphered plaintext p_i = c_i XOR k_i XOR c_(i-1), and the state becomes 10.
- R8: If the presented ciphertext differs from the sealed one in any bit, then on the 17th edge after E `sec_exc` and `regs_we` pulse once, `regs_out` is all zero, and the state becomes 00.
- R9: If `ret_pc` differs from the stored address, the same abort as in R8 occurs.
- R10: `ret_req` in the normal or running state, or `irq_req` while suspended, pulses `fault` for one cycle on the edge after acceptance and leaves the state unchanged.
- R11: In the running state `irq_req` takes priority over `exit_cmd` given in the same cycle: the image is sealed as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_cmd | input | 1 | Enter concealed mode |
| exit_cmd | input | 1 | Leave concealed mode |
| irq_req | input | 1 | Interrupt taken this cycle |
| ret_req | input | 1 | Return from interrupt handler |
| next_pc | input | 64 | Address of next concealed instruction, sampled with irq_req |
| ret_pc | input | 64 | Return address, sampled with ret_req |
| root_key | input | 128 | Device root key |
| regs_in | input | 512 | Flat register image, word 0 in the low bits |
| regs_out | output | 512 | Register image to write back |
| regs_we | output | 1 | One-cycle write strobe for regs_out |
| in_cem | output | 1 | Concealed mode state bit |
| suspended | output | 1 | Suspended state bit |
| handoff | output | 1 | Sealing finished, OS handler may run |
| resumed | output | 1 | Return check passed, registers restored |
| sec_exc | output | 1 | Return check failed, registers cleared |
| fault | output | 1 | Misuse of return or interrupt |

## Verification
A wrong state would show up first on the two state bits and the misuse strobe. A resume attempted in the wrong state yields `fault` on the next edge instead of a silent start. A corrupted engine word or key schedule shows at the seal handoff as ciphertext that differs from the independently computed value, 17 edges after the interrupt. A corrupted digest or address register does not show until the following return. There it turns an expected `resumed` into `sec_exc` with zeroed registers, or lets a tampered image through, on the 17th edge after the return.

// File: rtl/cem_pkg.sv
package cem_pkg;

    localparam int KEY_W  = 128;
    localparam int WORD_W = 32;
    localparam int N_WORDS = 16;
    localparam int ADDR_W = 64;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_RUN    = 3'd1,
        ST_SEAL   = 3'd2,
        ST_PARK   = 3'd3,
        ST_OPEN   = 3'd4
    } cem_state_t;

    // keystream word for register slot idx
    function automatic logic [31:0] ks_word(input logic [127:0] key, input logic [7:0] idx);
        return key[idx[1:0]*32 +: 32] ^ (32'(idx) * 32'h9E3779B9);
    endfunction

    // one digest step over a ciphertext word
    function automatic logic [127:0] tag_step(input logic [127:0] h, input logic [31:0] c,
                                              input logic [7:0] idx);
        return {h[94:0], h[127:95]} ^ {96'd0, c + 32'(idx)};
    endfunction

endpackage

// File: rtl/cem_seal_engine.sv
module cem_seal_engine
    import cem_pkg::*;
#(
    parameter int WORDS = N_WORDS,
    parameter int WW    = WORD_W,
    parameter int KW    = KEY_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode,      // 0 = seal, 1 = open
    input  logic [KW-1:0]       key_in,
    input  logic [WORDS*WW-1:0] img_in,
    output logic [WORDS*WW-1:0] img_out,
    output logic [KW-1:0]       tag_out,
    output logic                done
);
    localparam int IMG_W = WORDS * WW;
    localparam int CW    = $clog2(WORDS);

    logic [IMG_W-1:0] img_q;
    logic [KW-1:0]    key_q;
    logic [KW-1:0]    tag_q;
    logic [WW-1:0]    prev_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;
    logic             mode_q;
    logic             done_q;

    logic [WW-1:0] cur_w;
    logic [WW-1:0] out_w;
    logic [WW-1:0] ct_w;

    always_comb begin
        cur_w = img_q[int'(cnt_q)*WW +: WW];
        out_w = cur_w ^ ks_word(key_q, 8'(cnt_q)) ^ prev_q;
        ct_w  = mode_q ? cur_w : out_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q  <= '0;
            key_q  <= '0;
            tag_q  <= '0;
            prev_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            mode_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                img_q  <= img_in;
                key_q  <= key_in;
                tag_q  <= key_in;
                prev_q <= '0;
                cnt_q  <= '0;
                busy_q <= 1'b1;
                mode_q <= mode;
            end else if (busy_q) begin
                img_q[int'(cnt_q)*WW +: WW] <= out_w;
                prev_q <= ct_w;
                tag_q  <= tag_step(tag_q, ct_w, 8'(cnt_q));
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == CW'(WORDS - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign img_out = img_q;
    assign tag_out = tag_q;
    assign done    = done_q;

    AST_ENG_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R4
    AST_ENG_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R10

endmodule

// File: rtl/cem_ctrl_fsm.sv
module cem_ctrl_fsm
    import cem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_cmd,
    input  logic exit_cmd,
    input  logic irq_req,
    input  logic ret_req,
    input  logic eng_done,
    input  logic resume_ok,
    output logic in_cem,
    output logic suspended,
    output logic eng_start,
    output logic eng_mode,
    output logic cap_addr,
    output logic chk_addr,
    output logic do_seal,
    output logic do_open,
    output logic do_abort,
    output logic misuse
);
    cem_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        eng_start = 1'b0;
        eng_mode  = 1'b0;
        cap_addr  = 1'b0;
        chk_addr  = 1'b0;
        do_seal   = 1'b0;
        do_open   = 1'b0;
        do_abort  = 1'b0;
        misuse    = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                if (ret_req)        misuse  = 1'b1;
                else if (enter_cmd) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (irq_req) begin
                    eng_start = 1'b1;
                    cap_addr  = 1'b1;
                    state_d   = ST_SEAL;
                end else if (ret_req) begin
                    misuse = 1'b1;
                end else if (exit_cmd) begin
                    state_d = ST_NORMAL;
                end
            end
            ST_SEAL: begin
                if (eng_done) begin
                    do_seal = 1'b1;
                    state_d = ST_PARK;
                end
            end
            ST_PARK: begin
                if (irq_req) begin
                    misuse = 1'b1;
                end else if (ret_req) begin
                    eng_start = 1'b1;
                    eng_mode  = 1'b1;
                    chk_addr  = 1'b1;
                    state_d   = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (eng_done) begin
                    if (resume_ok) begin
                        do_open = 1'b1;
                        state_d = ST_RUN;
                    end else begin
                        do_abort = 1'b1;
                        state_d  = ST_NORMAL;
                    end
                end
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    assign in_cem    = (state_q != ST_NORMAL);
    assign suspended = (state_q == ST_PARK) || (state_q == ST_OPEN);

    AST_SEAL_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !eng_mode) |-> (state_q == ST_RUN)); // R3
    AST_OPEN_ONLY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_mode) |-> suspended); // R10

endmodule

// File: rtl/cem_irq_ctrl.sv
module cem_irq_ctrl
    import cem_pkg::*;
#(
    parameter int WORDS = N_WORDS,
    parameter int WW    = WORD_W,
    parameter int AW    = ADDR_W,
    parameter int KW    = KEY_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enter_cmd,
    input  logic                exit_cmd,
    input  logic                irq_req,
    input  logic                ret_req,
    input  logic [AW-1:0]       next_pc,
    input  logic [AW-1:0]       ret_pc,
    input  logic [KW-1:0]       root_key,
    input  logic [WORDS*WW-1:0] regs_in,
    output logic [WORDS*WW-1:0] regs_out,
    output logic                regs_we,
    output logic                in_cem,
    output logic                suspended,
    output logic                handoff,
    output logic                resumed,
    output logic                sec_exc,
    output logic                fault
);
    localparam int IMG_W = WORDS * WW;
    localparam int TW    = KW;

    logic             eng_start, eng_mode, eng_done;
    logic [IMG_W-1:0] eng_img;
    logic [TW-1:0]    eng_tag;
    logic             cap_addr, chk_addr, do_seal, do_open, do_abort, misuse;
    logic             resume_ok;

    logic [AW-1:0]    int_addr_q;
    logic [TW-1:0]    int_tag_q;
    logic             addr_ok_q;
    logic [IMG_W-1:0] regs_out_q;
    logic             regs_we_q, handoff_q, resumed_q, sec_exc_q, fault_q;

    assign resume_ok = addr_ok_q && (eng_tag == int_tag_q);

    cem_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_cmd (enter_cmd),
        .exit_cmd  (exit_cmd),
        .irq_req   (irq_req),
        .ret_req   (ret_req),
        .eng_done  (eng_done),
        .resume_ok (resume_ok),
        .in_cem    (in_cem),
        .suspended (suspended),
        .eng_start (eng_start),
        .eng_mode  (eng_mode),
        .cap_addr  (cap_addr),
        .chk_addr  (chk_addr),
        .do_seal   (do_seal),
        .do_open   (do_open),
        .do_abort  (do_abort),
        .misuse    (misuse)
    );

    cem_seal_engine #(.WORDS(WORDS), .WW(WW), .KW(KW)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .mode    (eng_mode),
        .key_in  (root_key),
        .img_in  (regs_in),
        .img_out (eng_img),
        .tag_out (eng_tag),
        .done    (eng_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_addr_q <= '0;
            int_tag_q  <= '0;
            addr_ok_q  <= 1'b0;
            regs_out_q <= '0;
            regs_we_q  <= 1'b0;
            handoff_q  <= 1'b0;
            resumed_q  <= 1'b0;
            sec_exc_q  <= 1'b0;
            fault_q    <= 1'b0;
        end else begin
            regs_we_q <= 1'b0;
            handoff_q <= 1'b0;
            resumed_q <= 1'b0;
            sec_exc_q <= 1'b0;
            fault_q   <= misuse;
            if (cap_addr) int_addr_q <= next_pc;
            if (chk_addr) addr_ok_q  <= (ret_pc == int_addr_q);
            if (do_seal) begin
                regs_out_q <= eng_img;
                int_tag_q  <= eng_tag;
                regs_we_q  <= 1'b1;
                handoff_q  <= 1'b1;
            end
            if (do_open) begin
                regs_out_q <= eng_img;
                regs_we_q  <= 1'b1;
                resumed_q  <= 1'b1;
            end
            if (do_abort) begin
                regs_out_q <= '0;
                int_tag_q  <= '0;
                int_addr_q <= '0;
                regs_we_q  <= 1'b1;
                sec_exc_q  <= 1'b1;
            end
        end
    end

    assign regs_out = regs_out_q;
    assign regs_we  = regs_we_q;
    assign handoff  = handoff_q;
    assign resumed  = resumed_q;
    assign sec_exc  = sec_exc_q;
    assign fault    = fault_q;

    AST_HANDOFF_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |-> (in_cem && suspended)); // R4
    AST_RESUME_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        resumed |-> (in_cem && !suspended)); // R7
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sec_exc |-> (!in_cem && regs_we && regs_out == '0)); // R8
    AST_FAULT_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (in_cem == $past(in_cem) && suspended == $past(suspended))); // R10
    AST_WE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        regs_we |-> (handoff || resumed || sec_exc)); // R4
    AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({handoff, resumed, sec_exc, fault})); // R10

endmodule

// File: tb/cem_irq_ctrl_bench.sv
module cem_irq_ctrl_bench;

    localparam int IMG = 512;
    localparam int EV_HAND = 0, EV_RES = 1, EV_EXC = 2, EV_FLT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_cmd = 0, exit_cmd = 0, irq_req = 0, ret_req = 0;
    logic [63:0]  next_pc = '0, ret_pc = '0;
    logic [127:0] root_key = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    logic [IMG-1:0] regs_in = '0;
    logic [IMG-1:0] regs_out;
    logic regs_we, in_cem, suspended, handoff, resumed, sec_exc, fault;

    always #2 clk = ~clk;  // 250 MHz

    cem_irq_ctrl u_cem_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .enter_cmd(enter_cmd), .exit_cmd(exit_cmd),
        .irq_req(irq_req), .ret_req(ret_req), .next_pc(next_pc), .ret_pc(ret_pc),
        .root_key(root_key), .regs_in(regs_in), .regs_out(regs_out), .regs_we(regs_we),
        .in_cem(in_cem), .suspended(suspended), .handoff(handoff), .resumed(resumed),
        .sec_exc(sec_exc), .fault(fault)
    );

    typedef struct {
        int             kind;
        logic [IMG-1:0] img;
        int             due;
        string          req;
    } exp_t;

    exp_t q[$];
    int pending = 0;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [IMG-1:0] act, input logic [IMG-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic chk_state(input logic e_cem, input logic e_susp, input string req);
        chk({in_cem, suspended} == {e_cem, e_susp}, req, "state bits",
            IMG'({in_cem, suspended}), IMG'({e_cem, e_susp}));
    endtask

    function automatic logic [31:0] kw(input logic [127:0] k, input int i);
        return k[(i % 4)*32 +: 32] ^ (32'(i) * 32'h9E3779B9);
    endfunction

    function automatic logic [IMG-1:0] enc(input logic [IMG-1:0] p, input logic [127:0] k);
        logic [IMG-1:0] c = '0;
        logic [31:0] prev = '0;
        for (int i = 0; i < 16; i++) begin
            c[i*32 +: 32] = p[i*32 +: 32] ^ kw(k, i) ^ prev;
            prev = c[i*32 +: 32];
        end
        return c;
    endfunction

    function automatic logic [IMG-1:0] mkimg(input logic [31:0] seed);
        logic [IMG-1:0] v = '0;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = seed * 32'(i + 3) ^ 32'hA5A5_0000;
        return v;
    endfunction

    // monitor: pops expectations as events appear
    always @(negedge clk) begin
        if (rst_n && (handoff || resumed || sec_exc || fault)) begin
            int k;
            k = handoff ? EV_HAND : resumed ? EV_RES : sec_exc ? EV_EXC : EV_FLT;
            if (q.size() == 0) begin
                chk(1'b0, "R3", "unexpected event", IMG'(k), IMG'(-1));
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(k == e.kind, e.req, "event kind", IMG'(k), IMG'(e.kind));
                chk(cyc == e.due, e.req, "event cycle", IMG'(cyc), IMG'(e.due));
                if (e.kind != EV_FLT) begin
                    chk(regs_we == 1'b1, e.req, "regs_we", IMG'(regs_we), IMG'(1));
                    chk(regs_out == e.img, e.req, "regs_out", regs_out, e.img);
                end
                pending--;
            end
        end
    end

    task automatic drive(input logic e, input logic x, input logic i, input logic r,
                         input logic [IMG-1:0] img, input logic [63:0] npc,
                         input logic [63:0] rpc, input int kind,
                         input logic [IMG-1:0] eimg, input string req);
        @(negedge clk);
        enter_cmd = e; exit_cmd = x; irq_req = i; ret_req = r;
        regs_in = img; next_pc = npc; ret_pc = rpc;
        if (kind >= 0) begin
            exp_t it;
            it.kind = kind;
            it.img  = eimg;
            it.due  = (kind == EV_FLT) ? cyc + 1 : cyc + 18;
            it.req  = req;
            q.push_back(it);
            pending++;
        end
        @(negedge clk);
        enter_cmd = 0; exit_cmd = 0; irq_req = 0; ret_req = 0;
        wait (pending == 0);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        logic [IMG-1:0] p1, p2, p3, p4, c1, c2, c3, c4;
        p1 = mkimg(32'h1234_5678); c1 = enc(p1, root_key);
        p2 = mkimg(32'hDEAD_BEEF); c2 = enc(p2, root_key);
        p3 = mkimg(32'h0000_0001); c3 = enc(p3, root_key);
        p4 = '0;                   c4 = enc(p4, root_key);

        repeat (4) @(negedge clk);
        chk_state(0, 0, "R1");
        chk({regs_we, handoff, resumed, sec_exc, fault} == 5'b0, "R1", "strobes in reset",
            IMG'({regs_we, handoff, resumed, sec_exc, fault}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state(0, 0, "R1");

        // R3: interrupt outside concealed mode
        drive(0, 0, 1, 0, p1, 64'h100, 0, -1, '0, "R3");
        repeat (20) @(negedge clk);
        chk_state(0, 0, "R3");

        // R10: return in normal state
        drive(0, 0, 0, 1, p1, 0, 64'h100, EV_FLT, '0, "R10");
        chk_state(0, 0, "R10");

        // R2: enter
        drive(1, 0, 0, 0, p1, 0, 0, -1, '0, "R2");
        chk_state(1, 0, "R2");

        // R10: return while running
        drive(0, 0, 0, 1, p1, 0, 0, EV_FLT, '0, "R10");
        chk_state(1, 0, "R10");

        // R4 R5 R6: seal first image
        drive(0, 0, 1, 0, p1, 64'h0000_0000_8000_1040, 0, EV_HAND, c1, "R4_R5");
        chk_state(1, 1, "R4");

        // R10: interrupt while suspended; R2: enter/exit ignored while suspended
        drive(0, 0, 1, 0, c1, 0, 0, EV_FLT, '0, "R10");
        chk_state(1, 1, "R10");
        drive(1, 1, 0, 0, c1, 0, 0, -1, '0, "R2");
        chk_state(1, 1, "R2");

        // R7 R6: good return
        drive(0, 0, 0, 1, c1, 0, 64'h0000_0000_8000_1040, EV_RES, p1, "R7_R6");
        chk_state(1, 0, "R7");

        // R9: wrong return address
        drive(0, 0, 1, 0, p2, 64'h2000, 0, EV_HAND, c2, "R5");
        drive(0, 0, 0, 1, c2, 0, 64'h2004, EV_EXC, '0, "R9");
        chk_state(0, 0, "R9");

        // R8: tampered ciphertext
        drive(1, 0, 0, 0, p3, 0, 0, -1, '0, "R2");
        drive(0, 0, 1, 0, p3, 64'h3000, 0, EV_HAND, c3, "R5");
        drive(0, 0, 0, 1, c3 ^ (IMG'(1) << 200), 0, 64'h3000, EV_EXC, '0, "R8");
        chk_state(0, 0, "R8");

        // R11: interrupt beats exit; all-zero image pattern
        drive(1, 0, 0, 0, p4, 0, 0, -1, '0, "R2");
        drive(0, 1, 1, 0, p4, 64'h4000, 0, EV_HAND, c4, "R11");
        chk_state(1, 1, "R11");
        drive(0, 0, 0, 1, c4, 0, 64'h4000, EV_RES, p4, "R7");
        drive(0, 1, 0, 0, p4, 0, 0, -1, '0, "R2");
        chk_state(0, 0, "R2");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R4", "leftover expectations", IMG'(q.size()), '0);
        finish_run();
    end

endmodule